// File: doc/BRIEF.md
# Quarter-Phase Asynchronous SRAM Bus Controller

This block connects an 8-bit processor memory bus to an external asynchronous static RAM with 16 address lines and a 16-bit data path divided into two byte lanes. Only the lower lane carries data. The controller runs from a clock at four times the processor rate. A free-running 2-bit phase counter splits each processor cycle into four quarters. The phase index is brought out so the processor side can align its own cycle to it: a processor cycle starts on the clock edge that enters phase 0.

The first quarter of every processor cycle is kept free for bus turnaround. In that quarter the sequencer sits in state ST_TURN with every strobe inactive and the data drivers released. On the edge that leaves phase 0, the sequencer samples the processor strobes and moves to one of three states. It goes to ST_READ when both the memory-request and read strobes are low. It goes to ST_WRITE when both the memory-request and write strobes are low. Otherwise it goes to ST_IDLE. It stays in that state through phases 1 to 3 and returns to ST_TURN on the edge that leaves phase 3. Every strobe comes from a flip-flop. The lower-lane write strobe is the OR of a rising-edge flop and a falling-edge flop, so it falls half a fast-clock period after the data drivers turn on. It rises a full quarter before the drivers are released.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is held, the phase index is 0. Chip enable, output enable and both write enables are high, the data drivers are off, and the read byte is 0x00.
- R2: The SRAM address output equals the processor address in every cycle, whatever the strobes are doing.
- R3: The phase index steps 0, 1, 2, 3 and wraps back to 0, advancing by one on every rising edge of the fast clock.
- R4: Throughout phase 0, chip enable, output enable and the lower write enable are high and the data drivers are off.
- R5: A read (memory-request low and read low when phase 0 ends) holds chip enable and output enable low through phases 1 to 3. During those phases the data drivers stay off and the lower write enable stays high. The data drivers and output enable are never active together.
- R6: A write (memory-request low and write low when phase 0 ends) holds chip enable low and output enable high through phases 1 to 3. It turns the data drivers on for those phases, with the processor write byte on bits 7:0 of the data output and zeros on bits 15:8.
- R7: During a write, the lower write enable falls on the falling clock edge in the middle of phase 1 and rises on the rising edge that enters phase 3. Address and data are identical at its fall and at its rise. It is only low while the drivers are on and chip enable is low.
- R8: The upper-lane write enable is high in every cycle.
- R9: During a read, the byte on the lower read lane is captured on the rising edge that ends phase 3. It is presented on the read-data output from phase 0 on and stays unchanged until the next read capture.
- R10: A cycle with memory-request high, or with memory-request low but both read and write high, keeps all strobes high and the drivers off for all four phases, and leaves the read byte unchanged.
- R11: The request type is taken only on the edge leaving phase 0. If the processor strobes are withdrawn during phases 1 to 3, the strobes for that cycle do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four times the processor rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_mreq_n | input | 1 | Memory request, active low |
| cpu_rd_n | input | 1 | Read strobe, active low |
| cpu_wr_n | input | 1 | Write strobe, active low |
| cpu_rdata | output | 8 | Captured read byte |
| cyc_phase | output | 2 | Current quarter of the processor cycle |
| sram_addr | output | 16 | SRAM address pins |
| sram_dq_out | output | 16 | Value driven onto the SRAM data pins |
| sram_dq_oe | output | 1 | Data pin driver enable, active high |
| sram_rd_lane | input | 8 | Lower byte lane read from the SRAM data pins |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_lo_n | output | 1 | Lower-lane write enable, active low |
| sram_we_hi_n | output | 1 | Upper-lane write enable, active low |

## Verification
The hardest situation to reach from the ports is a write strobe edge that lands while the address or data is changing, or a strobe that lags behind a change in the processor request. The stimulus creates both. It drives new addresses and data only at the start of phase 0, next to the write strobe's rise, and it withdraws the request strobes partway through phase 1 of a read. A behavioural SRAM in the bench latches the address and data at each fall of the write enable and compares them at the rise. It returns a known marker on the upper lane, so that reading from the wrong lane shows up as a data mismatch.

// File: rtl/sram_bus_pkg.sv
package sram_bus_pkg;

    localparam int PH_W = 2;

    typedef enum logic [1:0] {
        ST_TURN  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } seq_state_t;

endpackage

// File: rtl/sram_phase_gen.sv
module sram_phase_gen #(
    parameter int PH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_bus_pkg::*;
#(
    parameter int PW = PH_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] phase,
    input  logic          mreq_n,
    input  logic          rd_n,
    input  logic          wr_n,
    output logic          ce_n,
    output logic          oe_n,
    output logic          drv_en,
    output logic          we_early_n,
    output logic          capture_en
);

    localparam logic [PW-1:0] PH_FIRST = '0;
    localparam logic [PW-1:0] PH_LAST  = '1;

    seq_state_t    state;
    seq_state_t    nxt;
    logic [PW-1:0] phase_nxt;
    logic          rd_req;
    logic          wr_req;

    assign rd_req    = !mreq_n && !rd_n;
    assign wr_req    = !mreq_n && !wr_n;
    assign phase_nxt = phase + 1'b1;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_TURN: begin
                if (rd_req) begin
                    nxt = ST_READ;
                end else if (wr_req) begin
                    nxt = ST_WRITE;
                end else begin
                    nxt = ST_IDLE;
                end
            end
            ST_IDLE, ST_READ, ST_WRITE: begin
                if (phase == PH_LAST) begin
                    nxt = ST_TURN;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_TURN;
        end else begin
            state <= nxt;
        end
    end

    // registered strobes, decoded from the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_n       <= 1'b1;
            oe_n       <= 1'b1;
            drv_en     <= 1'b0;
            we_early_n <= 1'b1;
        end else begin
            ce_n       <= !((nxt == ST_READ) || (nxt == ST_WRITE));
            oe_n       <= (nxt != ST_READ);
            drv_en     <= (nxt == ST_WRITE);
            we_early_n <= !((nxt == ST_WRITE) && (phase_nxt != PH_LAST)
                            && (phase_nxt != PH_FIRST));
        end
    end

    assign capture_en = (state == ST_READ) && (phase == PH_LAST);

endmodule

// File: rtl/sram_we_shaper.sv
module sram_we_shaper (
    input  logic clk,
    input  logic rst_n,
    input  logic early_n,
    output logic we_n
);

    logic late_n;

    // half-period delayed copy, taken on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            late_n <= 1'b1;
        end else begin
            late_n <= early_n;
        end
    end

    // low only while both flops are low: falls late, rises early
    assign we_n = early_n | late_n;

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [BYTE_W-1:0] lane_in,
    output logic [BYTE_W-1:0] byte_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
        end else if (en) begin
            byte_q <= lane_in;
        end
    end

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
    import sram_bus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic [BYTE_W-1:0]    cpu_wdata,
    input  logic                 cpu_mreq_n,
    input  logic                 cpu_rd_n,
    input  logic                 cpu_wr_n,
    output logic [BYTE_W-1:0]    cpu_rdata,
    output logic [PH_W-1:0]      cyc_phase,
    output logic [ADDR_W-1:0]    sram_addr,
    output logic [DATA_W-1:0]    sram_dq_out,
    output logic                 sram_dq_oe,
    input  logic [BYTE_W-1:0]    sram_rd_lane,
    output logic                 sram_ce_n,
    output logic                 sram_oe_n,
    output logic                 sram_we_lo_n,
    output logic                 sram_we_hi_n
);

    localparam int UPPER_W = DATA_W - BYTE_W;

    logic we_early_n;
    logic capture_en;

    sram_phase_gen #(.PH_W(PH_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (cyc_phase)
    );

    sram_seq_fsm #(.PW(PH_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (cyc_phase),
        .mreq_n     (cpu_mreq_n),
        .rd_n       (cpu_rd_n),
        .wr_n       (cpu_wr_n),
        .ce_n       (sram_ce_n),
        .oe_n       (sram_oe_n),
        .drv_en     (sram_dq_oe),
        .we_early_n (we_early_n),
        .capture_en (capture_en)
    );

    sram_we_shaper u_we (
        .clk     (clk),
        .rst_n   (rst_n),
        .early_n (we_early_n),
        .we_n    (sram_we_lo_n)
    );

    sram_rd_capture #(.BYTE_W(BYTE_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (capture_en),
        .lane_in (sram_rd_lane),
        .byte_q  (cpu_rdata)
    );

    assign sram_addr    = cpu_addr;
    assign sram_dq_out  = {{UPPER_W{1'b0}}, cpu_wdata};
    assign sram_we_hi_n = 1'b1;

endmodule

// File: rtl/sram_bus_ctrl_chk.sv
module sram_bus_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cyc_phase,
    input logic [7:0] cpu_rdata,
    input logic       sram_dq_oe,
    input logic       sram_ce_n,
    input logic       sram_oe_n,
    input logic       sram_we_lo_n,
    input logic       sram_we_hi_n
);

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cyc_phase == $past(cyc_phase) + 2'd1)); // R3

    AST_TURN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_phase == 2'd0) |-> (sram_ce_n && sram_oe_n && sram_we_lo_n && !sram_dq_oe)); // R4

    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n); // R5

    AST_OE_WITH_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> !sram_ce_n); // R5

    AST_WE_UNDER_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_lo_n |-> (sram_dq_oe && !sram_ce_n)); // R7

    AST_UPPER_WE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we_hi_n); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_phase != 2'd0) |-> $stable(cpu_rdata)); // R9

endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_phase    (cyc_phase),
    .cpu_rdata    (cpu_rdata),
    .sram_dq_oe   (sram_dq_oe),
    .sram_ce_n    (sram_ce_n),
    .sram_oe_n    (sram_oe_n),
    .sram_we_lo_n (sram_we_lo_n),
    .sram_we_hi_n (sram_we_hi_n)
);

// File: tb/sram_bus_ctrl_test.sv
module sram_bus_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0;
    logic [7:0]  cpu_wdata = 8'h0;
    logic        cpu_mreq_n = 1'b1;
    logic        cpu_rd_n = 1'b1;
    logic        cpu_wr_n = 1'b1;
    logic [7:0]  cpu_rdata;
    logic [1:0]  cyc_phase;
    logic [15:0] sram_addr;
    logic [15:0] sram_dq_out;
    logic        sram_dq_oe;
    logic [15:0] sram_bus_in = 16'hFFFF;
    logic        sram_ce_n, sram_oe_n, sram_we_lo_n, sram_we_hi_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [7:0]  mem    [int unsigned];
    logic [7:0]  shadow [int unsigned];
    logic [7:0]  expq   [$];
    logic [7:0]  last_rd = 8'h00;
    logic [7:0]  popped;
    logic [15:0] fall_a;
    logic [7:0]  fall_d;

    localparam int K_IDLE = 0, K_READ = 1, K_WRITE = 2, K_NOPE = 3;

    always #4 clk = ~clk;

    sram_bus_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_mreq_n(cpu_mreq_n), .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n),
        .cpu_rdata(cpu_rdata), .cyc_phase(cyc_phase), .sram_addr(sram_addr),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
        .sram_rd_lane(sram_bus_in[7:0]), .sram_ce_n(sram_ce_n),
        .sram_oe_n(sram_oe_n), .sram_we_lo_n(sram_we_lo_n),
        .sram_we_hi_n(sram_we_hi_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural SRAM: upper lane returns a marker, lower lane the stored byte
    always @(posedge clk or negedge clk) begin
        #1;
        if (!sram_ce_n && !sram_oe_n)
            sram_bus_in = {8'hA5, (mem.exists(sram_addr) ? mem[sram_addr] : 8'h00)};
        else
            sram_bus_in = 16'hFFFF;
    end

    always @(negedge sram_we_lo_n) if (rst_n) begin
        fall_a = sram_addr;
        fall_d = sram_dq_out[7:0];
        chk(!sram_ce_n && sram_dq_oe, "R7", "ce/drive at we fall", {sram_ce_n, sram_dq_oe}, 1);
    end

    always @(posedge sram_we_lo_n) if (rst_n) begin
        chk(sram_addr == fall_a, "R7", "address hold at we rise", sram_addr, fall_a);
        chk(sram_dq_out[7:0] == fall_d, "R7", "data hold at we rise", sram_dq_out[7:0], fall_d);
        chk(sram_dq_oe, "R7", "drive at we rise", sram_dq_oe, 1);
        mem[sram_addr] = sram_dq_out[7:0];
    end

    // scoreboard monitor
    initial begin
        bit rd_seen = 0;
        forever begin
            @(posedge clk); #2;
            if (rst_n) begin
                chk(sram_we_hi_n == 1'b1, "R8", "upper we", sram_we_hi_n, 1);
                chk(!(sram_dq_oe && !sram_oe_n), "R5", "contention", {sram_dq_oe, sram_oe_n}, 1);
                if (cyc_phase == 2'd0 && rd_seen) begin
                    if (expq.size() == 0) begin
                        chk(0, "R9", "unexpected read", cpu_rdata, 0);
                    end else begin
                        popped = expq.pop_front();
                        chk(cpu_rdata == popped, "R9", "read byte", cpu_rdata, popped);
                    end
                end
                rd_seen = (cyc_phase == 2'd3) && !sram_oe_n;
            end
        end
    end

    task automatic do_cycle(input int kind, input logic [15:0] a,
                            input logic [7:0] d, input bit drop);
        do begin @(posedge clk); #2; end while (cyc_phase != 2'd0);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_mreq_n = !(kind == K_READ || kind == K_WRITE || kind == K_NOPE);
        cpu_rd_n   = !(kind == K_READ || kind == K_IDLE);
        cpu_wr_n   = !(kind == K_WRITE);
        if (kind == K_READ) begin
            last_rd = shadow.exists(a) ? shadow[a] : 8'h00;
            expq.push_back(last_rd);
        end
        if (kind == K_WRITE) shadow[a] = d;
        for (int p = 1; p <= 3; p++) begin
            @(posedge clk); #2;
            chk(cyc_phase == p[1:0], "R3", "phase index", cyc_phase, p);
            chk(sram_addr == a, "R2", "address follow", sram_addr, a);
            if (kind == K_READ) begin
                chk(!sram_ce_n && !sram_oe_n, "R5", "read ce/oe", {sram_ce_n, sram_oe_n}, 0);
                chk(!sram_dq_oe && sram_we_lo_n, "R5", "read drive/we", {sram_dq_oe, sram_we_lo_n}, 1);
                if (drop && p > 1)
                    chk(!sram_ce_n && !sram_oe_n, "R11", "strobes held after withdraw",
                        {sram_ce_n, sram_oe_n}, 0);
            end else if (kind == K_WRITE) begin
                chk(!sram_ce_n && sram_oe_n, "R6", "write ce/oe", {sram_ce_n, sram_oe_n}, 1);
                chk(sram_dq_oe, "R6", "write drive", sram_dq_oe, 1);
                chk(sram_dq_out == {8'h00, d}, "R6", "write data", sram_dq_out, {8'h00, d});
                chk(sram_we_lo_n == (p != 2), "R7", "we early half", sram_we_lo_n, (p != 2));
            end else begin
                chk(sram_ce_n && sram_oe_n && sram_we_lo_n && !sram_dq_oe, "R10",
                    "idle strobes", {sram_ce_n, sram_oe_n, sram_we_lo_n, sram_dq_oe}, 4'b1110);
            end
            #4;
            if (kind == K_WRITE)
                chk(sram_we_lo_n == (p == 3), "R7", "we late half", sram_we_lo_n, (p == 3));
            else
                chk(sram_we_lo_n, "R7", "we high outside write", sram_we_lo_n, 1);
            if (drop && p == 1) begin
                cpu_mreq_n = 1'b1; cpu_rd_n = 1'b1; cpu_wr_n = 1'b1;
            end
        end
        @(posedge clk); #2;
        chk(cyc_phase == 2'd0, "R3", "phase wrap", cyc_phase, 0);
        chk(sram_ce_n && sram_oe_n && sram_we_lo_n && !sram_dq_oe, "R4", "turnaround quiet",
            {sram_ce_n, sram_oe_n, sram_we_lo_n, sram_dq_oe}, 4'b1110);
        if (kind == K_IDLE || kind == K_NOPE)
            chk(cpu_rdata == last_rd, "R10", "read byte kept", cpu_rdata, last_rd);
        cpu_mreq_n = 1'b1; cpu_rd_n = 1'b1; cpu_wr_n = 1'b1;
    endtask

    initial begin
        #(8 * 5000);
        if (!done) begin
            total++; bad++;
            $display("FAIL R3 watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk(cyc_phase == 2'd0, "R1", "reset phase", cyc_phase, 0);
        chk(sram_ce_n && sram_oe_n && sram_we_lo_n && sram_we_hi_n, "R1", "reset strobes",
            {sram_ce_n, sram_oe_n, sram_we_lo_n, sram_we_hi_n}, 4'hF);
        chk(!sram_dq_oe, "R1", "reset drive", sram_dq_oe, 0);
        chk(cpu_rdata == 8'h00, "R1", "reset read byte", cpu_rdata, 0);
        rst_n = 1'b1;

        do_cycle(K_WRITE, 16'h0012, 8'h3C, 0);
        do_cycle(K_WRITE, 16'hFFFF, 8'hA7, 0);
        do_cycle(K_WRITE, 16'h0000, 8'h5A, 0);
        do_cycle(K_WRITE, 16'h8001, 8'hFF, 0);
        do_cycle(K_READ,  16'hFFFF, 8'h00, 0);
        do_cycle(K_IDLE,  16'h1234, 8'h99, 0);
        do_cycle(K_NOPE,  16'h4321, 8'h11, 0);
        do_cycle(K_READ,  16'h0012, 8'h00, 0);
        do_cycle(K_READ,  16'h0000, 8'h00, 1);
        do_cycle(K_READ,  16'h8001, 8'h00, 0);
        do_cycle(K_WRITE, 16'h0012, 8'hC3, 0);
        do_cycle(K_READ,  16'h0012, 8'h00, 0);
        do_cycle(K_READ,  16'h7777, 8'h00, 0);
        do_cycle(K_IDLE,  16'h0000, 8'h00, 0);
        repeat (8) @(posedge clk);
        #2;
        chk(expq.size() == 0, "R9", "all reads returned", expq.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule